// File: doc/BRIEF.md
# Binary Set-Combine and Output Routing Stage

This stage sits at the end of a binary compute unit that works on streams of 1-bit pixels. Each cycle it gets a valid-qualified set of aligned 1-bit sources: the unit's raw input, two logic element results, a reduction result and a median result. Two operand selectors each pick one of the four computed results. A 1-bit set element applies the configured set function to the two chosen operands. An output selector then decides which signal leaves the unit: the raw input, any computed result, or the set result.

The selector and operation codes are static configuration fields. The stage has one register layer, so every route has the same one-cycle latency. That keeps the output aligned with its valid flag, whichever route is chosen. When no valid input arrives, the output pixel keeps its last value.

Top module: `bsr_stage`

## Requirements
- R1: While reset is high, and on the first clock after it falls with no valid input, `out_valid` and `out_pix` are 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and each valid input gives exactly one valid output.
- R3: Operand select codes (2 bits, the same for operand A and operand B) pick a source as follows: 0 = logic result A, 1 = logic result B, 2 = reduction result, 3 = median result.
- R4: Set codes 1 (union) and 5 (saturating addition) give A OR B. Code 2 (intersection) gives A AND B.
- R5: Set code 3 (complement) gives NOT A. Code 4 (difference) gives A AND NOT B.
- R6: Set code 0 (straight-through) gives operand A, whatever operand B is.
- R7: Set codes 6 and 7 give a set result of 0.
- R8: Output select codes (3 bits) route the stage output as follows: 0 = raw input, 1 = logic result A, 2 = logic result B, 3 = reduction result, 4 = median result, 5 = set result. The selected value appears one clock after the valid input.
- R9: Output select codes 6 and 7 give an output of 0.
- R10: In a cycle without a valid input, `out_pix` keeps the value it held after the last valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | All sources carry a valid, aligned pixel |
| raw_pix | input | 1 | Unit's unprocessed input pixel |
| lgc_a_pix | input | 1 | First logic element result |
| lgc_b_pix | input | 1 | Second logic element result |
| red_pix | input | 1 | Reduction result |
| med_pix | input | 1 | Median result |
| cfg_op | input | 3 | Set operation code |
| cfg_sel_a | input | 2 | Operand A source select |
| cfg_sel_b | input | 2 | Operand B source select |
| cfg_out_sel | input | 3 | Output route select |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 1 | Routed output pixel |

## Verification
The assertions assume that the configuration fields and all five sources are stable in any cycle where `in_valid` is high. They also assume `in_valid` is low while reset is high, so the one-cycle comparisons only link values from the same cycle. The stimulus sets every field and source together at the falling edge, keeps `in_valid` low during reset, and mixes back-to-back valid cycles with idle gaps. This exercises both the latency relation and the hold behaviour. It covers every operation code with every operand pairing and every source pattern, and every output route, including the reserved codes.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int OP_W     = 3;
    localparam int OPSEL_W  = 2;
    localparam int OUTSEL_W = 3;
    localparam int NUM_OPND = 2;

    typedef enum logic [OP_W-1:0] {
        OP_PASS  = 3'd0,
        OP_UNION = 3'd1,
        OP_ISECT = 3'd2,
        OP_NOT   = 3'd3,
        OP_DIFF  = 3'd4,
        OP_ADD   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } set_op_e;

    typedef enum logic [OPSEL_W-1:0] {
        SRC_LGC_A = 2'd0,
        SRC_LGC_B = 2'd1,
        SRC_RED   = 2'd2,
        SRC_MED   = 2'd3
    } opnd_sel_e;

    typedef enum logic [OUTSEL_W-1:0] {
        ROUTE_RAW   = 3'd0,
        ROUTE_LGC_A = 3'd1,
        ROUTE_LGC_B = 3'd2,
        ROUTE_RED   = 3'd3,
        ROUTE_MED   = 3'd4,
        ROUTE_SET   = 3'd5,
        ROUTE_RSV6  = 3'd6,
        ROUTE_RSV7  = 3'd7
    } route_sel_e;

    typedef struct packed {
        logic raw;
        logic lgc_a;
        logic lgc_b;
        logic red;
        logic med;
    } pix_src_t;

    function automatic logic pick_operand(input pix_src_t s, input opnd_sel_e sel);
        logic v;
        case (sel)
            SRC_LGC_A: v = s.lgc_a;
            SRC_LGC_B: v = s.lgc_b;
            SRC_RED:   v = s.red;
            default:   v = s.med;
        endcase
        return v;
    endfunction

    function automatic logic set_apply(input set_op_e op, input logic a, input logic b);
        logic v;
        case (op)
            OP_PASS:  v = a;
            OP_UNION: v = a | b;
            OP_ISECT: v = a & b;
            OP_NOT:   v = ~a;
            OP_DIFF:  v = a & ~b;
            OP_ADD:   v = a | b;
            default:  v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bsr_operand_mux.sv
module bsr_operand_mux
    import bsr_pkg::*;
(
    input  pix_src_t               src,
    input  logic [OPSEL_W-1:0]     sel,
    output logic                   opnd
);
    always_comb begin
        opnd = pick_operand(src, opnd_sel_e'(sel));
    end
endmodule

// File: rtl/bsr_set_elem.sv
module bsr_set_elem
    import bsr_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            opnd_a,
    input  logic            opnd_b,
    output logic            res
);
    always_comb begin
        res = set_apply(set_op_e'(op), opnd_a, opnd_b);
    end
endmodule

// File: rtl/bsr_out_mux.sv
module bsr_out_mux
    import bsr_pkg::*;
(
    input  pix_src_t            src,
    input  logic                set_res,
    input  logic [OUTSEL_W-1:0] sel,
    output logic                pix
);
    always_comb begin
        case (route_sel_e'(sel))
            ROUTE_RAW:   pix = src.raw;
            ROUTE_LGC_A: pix = src.lgc_a;
            ROUTE_LGC_B: pix = src.lgc_b;
            ROUTE_RED:   pix = src.red;
            ROUTE_MED:   pix = src.med;
            ROUTE_SET:   pix = set_res;
            default:     pix = 1'b0;
        endcase
    end
endmodule

// File: rtl/bsr_stage.sv
module bsr_stage
    import bsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic                raw_pix,
    input  logic                lgc_a_pix,
    input  logic                lgc_b_pix,
    input  logic                red_pix,
    input  logic                med_pix,
    input  logic [OP_W-1:0]     cfg_op,
    input  logic [OPSEL_W-1:0]  cfg_sel_a,
    input  logic [OPSEL_W-1:0]  cfg_sel_b,
    input  logic [OUTSEL_W-1:0] cfg_out_sel,
    output logic                out_valid,
    output logic                out_pix
);
    pix_src_t                         src;
    logic [NUM_OPND-1:0][OPSEL_W-1:0] opnd_sel;
    logic [NUM_OPND-1:0]              opnd;
    logic                             set_res;
    logic                             route_pix;

    assign src      = '{raw: raw_pix, lgc_a: lgc_a_pix, lgc_b: lgc_b_pix,
                        red: red_pix, med: med_pix};
    assign opnd_sel = {cfg_sel_b, cfg_sel_a};

    for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
        bsr_operand_mux u_mux (
            .src  (src),
            .sel  (opnd_sel[g]),
            .opnd (opnd[g])
        );
    end

    bsr_set_elem u_set (
        .op     (cfg_op),
        .opnd_a (opnd[0]),
        .opnd_b (opnd[1]),
        .res    (set_res)
    );

    bsr_out_mux u_route (
        .src     (src),
        .set_res (set_res),
        .sel     (cfg_out_sel),
        .pix     (route_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_pix <= route_pix;
        end
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_pix));
    assert_raw_route_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_out_sel == ROUTE_RAW) |=> (out_pix == $past(raw_pix)));
    assert_reserved_route_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_out_sel >= ROUTE_RSV6) |=> !out_pix);
    assert_reserved_op_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_out_sel == ROUTE_SET && cfg_op >= OP_RSV6) |=> !out_pix);
    assert_pass_ignores_b_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_out_sel == ROUTE_SET && cfg_op == OP_PASS
         && cfg_sel_a == SRC_RED) |=> (out_pix == $past(red_pix)));
endmodule

// File: tb/bsr_stage_test.sv
module bsr_stage_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       raw_pix = 1'b0, lgc_a_pix = 1'b0, lgc_b_pix = 1'b0;
    logic       red_pix = 1'b0, med_pix = 1'b0;
    logic [2:0] cfg_op = 3'd0;
    logic [1:0] cfg_sel_a = 2'd0, cfg_sel_b = 2'd0;
    logic [2:0] cfg_out_sel = 3'd0;
    logic       out_valid, out_pix;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 0;
    bit    exp_q[$];
    string tag_q[$];
    bit    have_last = 0;
    bit    last_exp = 0;

    always #4 clk = ~clk;

    bsr_stage uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .raw_pix(raw_pix), .lgc_a_pix(lgc_a_pix), .lgc_b_pix(lgc_b_pix),
        .red_pix(red_pix), .med_pix(med_pix),
        .cfg_op(cfg_op), .cfg_sel_a(cfg_sel_a), .cfg_sel_b(cfg_sel_b),
        .cfg_out_sel(cfg_out_sel), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic bit pick(input bit [1:0] s, input bit [4:0] v);
        // v = {raw, la, lb, red, med}
        case (s)
            2'd0: return v[3];
            2'd1: return v[2];
            2'd2: return v[1];
            default: return v[0];
        endcase
    endfunction

    function automatic bit model(input bit [2:0] op, input bit [1:0] sa, input bit [1:0] sb,
                                 input bit [2:0] os, input bit [4:0] v);
        bit a, b, s;
        a = pick(sa, v);
        b = pick(sb, v);
        case (op)
            3'd0: s = a;
            3'd1: s = a | b;
            3'd2: s = a & b;
            3'd3: s = !a;
            3'd4: s = a & !b;
            3'd5: s = a | b;
            default: s = 1'b0;
        endcase
        case (os)
            3'd0: return v[4];
            3'd1: return v[3];
            3'd2: return v[2];
            3'd3: return v[1];
            3'd4: return v[0];
            3'd5: return s;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input bit [2:0] op, input bit [1:0] sa, input bit [1:0] sb,
                        input bit [2:0] os, input bit [4:0] v, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        {raw_pix, lgc_a_pix, lgc_b_pix, red_pix, med_pix} = v;
        cfg_op = op; cfg_sel_a = sa; cfg_sel_b = sb; cfg_out_sel = os;
        exp_q.push_back(model(op, sa, sb, os, v));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            {raw_pix, lgc_a_pix, lgc_b_pix, red_pix, med_pix} = ~{raw_pix, lgc_a_pix,
                lgc_b_pix, red_pix, med_pix};
        end
    endtask

    function automatic string op_tag(input bit [2:0] op);
        case (op)
            3'd0: return "R3,R6";
            3'd1, 3'd2, 3'd5: return "R3,R4";
            3'd3, 3'd4: return "R3,R5";
            default: return "R7";
        endcase
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            have_last <= 0;
        end else if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected out_valid", 1, 0);
            end else begin
                bit e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_pix == e, t, out_pix, e);
                have_last <= 1;
                last_exp  <= e;
            end
        end else if (have_last) begin
            check(out_pix == last_exp, "R10 hold", out_pix, last_exp);
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(out_pix == 0, "R1 out_pix", out_pix, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_pix == 0, "R1 after release", {out_valid, out_pix}, 0);

        // R3..R7: every op, operand pairing and source pattern through the set route
        for (int op = 0; op < 8; op++)
            for (int sa = 0; sa < 4; sa++)
                for (int sb = 0; sb < 4; sb++)
                    for (int v = 0; v < 16; v++)
                        send(op[2:0], sa[1:0], sb[1:0], 3'd5, {1'b0, v[3:0]}, op_tag(op[2:0]));
        idle(3);

        // R8, R9: every route with every source pattern, gaps interleaved (R2, R10)
        for (int os = 0; os < 8; os++) begin
            for (int v = 0; v < 32; v++) begin
                send(3'd2, 2'd0, 2'd3, os[2:0], v[4:0], (os < 6) ? "R8" : "R9");
                if (v % 5 == 4) idle(2);
            end
        end
        idle(3);

        // R6: straight-through ignores operand B
        for (int v = 0; v < 16; v++) send(3'd0, 2'd2, 2'd1, 3'd5, {1'b1, v[3:0]}, "R6");
        idle(3);

        // R10: a 1 then idle with toggling sources must keep the 1
        send(3'd0, 2'd0, 2'd0, 3'd0, 5'b10000, "R8");
        idle(4);
        check(out_pix == 1'b1, "R10 held one", out_pix, 1);

        check(exp_q.size() == 0, "R2 all outputs produced", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule